// File: doc/BRIEF.md
# PWM Pair ADC Trigger Generator

The block drives a triangle counter shared by a pair of PWM channels and turns chosen points on that triangle into single-clock pulses that start an ADC conversion. The counter climbs from 0 to a programmed top value and then falls back to 0, over and over. Each pass through zero and each arrival at the top value is an event. So is each match between the count and one of two compare values, and a compare match is labelled by the direction of the step that follows it.

Two trigger outputs read these events independently. Each output has a 4-bit source select and an enable. The chosen event is gated by the enable and registered, so a pulse appears exactly one clock after the counter shows the value that caused it. Configuration arrives on plain input ports. A value read while the clock edge occurs takes effect at that edge.

Top module: `pwm_pair_adc_trig`

## Requirements
- R1: While `rst` is high at a rising clock edge, `cnt_o` becomes 0, the counting direction becomes upward, and `trig0_o` and `trig1_o` become 0.
- R2: With `top_i` nonzero, `cnt_o` steps by one each clock: up from 0 to `top_i`, then down to 0, then up again. When `top_i` is 0, `cnt_o` stays at 0.
- R3: If `top_i` is lowered to or below the current count while the counter is rising, the next step is downward.
- R4: Select code 0h pulses a trigger in the clock after `cnt_o` reads 0.
- R5: Select code 1h pulses a trigger in the clock after `cnt_o` equals `top_i`.
- R6: Select code 2h pulses a trigger in the clock after `cnt_o` reads 0 or equals `top_i`.
- R7: Select code 3h pulses a trigger in the clock after `cnt_o` equals `cmp0_i` when the next step is upward. It never pulses when `cmp0_i` equals `top_i`. The next step is upward when the count is 0, or when the counter is rising and the count is below `top_i`.
- R8: Select code 4h pulses a trigger in the clock after `cnt_o` equals `cmp0_i` when the next step is downward. It never pulses when `cmp0_i` is 0.
- R9: Select codes 8h and 9h behave like 3h and 4h, but use `cmp1_i`.
- R10: Select codes 5h, 6h, 7h and Ah to Fh never produce a pulse.
- R11: An output whose enable is 0 at a clock edge is 0 after that edge, whatever its select code.
- R12: The two outputs are independent. Each uses only its own select and enable, so each can pulse on a different event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| top_i | input | 16 | Turning value of the triangle count |
| cmp0_i | input | 16 | Compare value, first channel |
| cmp1_i | input | 16 | Compare value, second channel |
| src0_i | input | 4 | Event select, trigger 0 |
| arm0_i | input | 1 | Enable, trigger 0 |
| src1_i | input | 4 | Event select, trigger 1 |
| arm1_i | input | 1 | Enable, trigger 1 |
| cnt_o | output | 16 | Current count |
| trig0_o | output | 1 | Trigger 0 pulse |
| trig1_o | output | 1 | Trigger 1 pulse |

## Verification
The hardest cases to reach are the turning points. There, a compare value equal to 0 or to the top value must give exactly one direction-labelled event and no second one. Nearby is the reversal forced when the top value drops beneath a rising count. The stimulus targets these cases directly: it pins the compare values to 0, to the top value and to one above it, and it shrinks the top value in the middle of a rising ramp. It then sweeps all sixteen select codes with the enable both set and clear, and follows with random segments that keep the top value small, so that turns happen often.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;

    localparam int SEL_W = 4;
    localparam int NUM_CMP = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_ZERO     = 4'h0,
        SRC_TOP      = 4'h1,
        SRC_ZERO_TOP = 4'h2,
        SRC_A_RISE   = 4'h3,
        SRC_A_FALL   = 4'h4,
        SRC_B_RISE   = 4'h8,
        SRC_B_FALL   = 4'h9
    } src_e;

    typedef struct packed {
        logic at_zero;
        logic at_top;
        logic a_rise;
        logic a_fall;
        logic b_rise;
        logic b_fall;
    } evt_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } match_t;

    function automatic logic pick_event(logic [SEL_W-1:0] sel, evt_t e);
        logic hit;
        case (sel)
            SRC_ZERO:     hit = e.at_zero;
            SRC_TOP:      hit = e.at_top;
            SRC_ZERO_TOP: hit = e.at_zero | e.at_top;
            SRC_A_RISE:   hit = e.a_rise;
            SRC_A_FALL:   hit = e.a_fall;
            SRC_B_RISE:   hit = e.b_rise;
            SRC_B_FALL:   hit = e.b_fall;
            default:      hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pwm_updown_cnt.sv
module pwm_updown_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] top_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             step_up_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             rising_q;
    logic             step_up;
    logic [CNT_W-1:0] cnt_d;

    // direction of the step leaving the current value
    always_comb begin
        if (cnt_q == '0) begin
            step_up = 1'b1;
        end else begin
            step_up = rising_q && (cnt_q < top_i);
        end
    end

    always_comb begin
        if (top_i == '0) begin
            cnt_d = '0;
        end else if (step_up) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            rising_q <= 1'b1;
        end else begin
            cnt_q    <= cnt_d;
            rising_q <= step_up;
        end
    end

    assign cnt_o     = cnt_q;
    assign step_up_o = step_up;
endmodule

// File: rtl/pwm_cmp_detect.sv
module pwm_cmp_detect
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             step_up_i,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp_i,
    output match_t           match_o
);
    logic equal;

    assign equal = (cnt_i == cmp_i);

    always_comb begin
        match_o.rise = equal && step_up_i && (cmp_i != top_i);
        match_o.fall = equal && !step_up_i && (cmp_i != '0);
    end
endmodule

// File: rtl/pwm_trig_out.sv
module pwm_trig_out
    import pwm_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             arm_i,
    output logic             trig_o
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= 1'b0;
        end else begin
            trig_q <= arm_i && pick_event(sel_i, evt_i);
        end
    end

    assign trig_o = trig_q;
endmodule

// File: rtl/pwm_pair_adc_trig.sv
module pwm_pair_adc_trig
    import pwm_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] top_i,
    input  logic [CNT_W-1:0] cmp0_i,
    input  logic [CNT_W-1:0] cmp1_i,
    input  logic [3:0]       src0_i,
    input  logic             arm0_i,
    input  logic [3:0]       src1_i,
    input  logic             arm1_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             trig0_o,
    output logic             trig1_o
);
    localparam int NUM_OUT = 2;

    logic [CNT_W-1:0] cnt;
    logic             step_up;
    logic [CNT_W-1:0] cmp_arr [NUM_CMP];
    match_t           match   [NUM_CMP];
    evt_t             evt;
    logic [SEL_W-1:0] sel_arr [NUM_OUT];
    logic             arm_arr [NUM_OUT];
    logic             trig_arr[NUM_OUT];

    assign cmp_arr[0] = cmp0_i;
    assign cmp_arr[1] = cmp1_i;
    assign sel_arr[0] = src0_i;
    assign sel_arr[1] = src1_i;
    assign arm_arr[0] = arm0_i;
    assign arm_arr[1] = arm1_i;

    pwm_updown_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk       (clk),
        .rst       (rst),
        .top_i     (top_i),
        .cnt_o     (cnt),
        .step_up_o (step_up)
    );

    for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
        pwm_cmp_detect #(.CNT_W(CNT_W)) i_det (
            .cnt_i     (cnt),
            .step_up_i (step_up),
            .top_i     (top_i),
            .cmp_i     (cmp_arr[c]),
            .match_o   (match[c])
        );
    end

    always_comb begin
        evt.at_zero = (cnt == '0);
        evt.at_top  = (cnt == top_i);
        evt.a_rise  = match[0].rise;
        evt.a_fall  = match[0].fall;
        evt.b_rise  = match[1].rise;
        evt.b_fall  = match[1].fall;
    end

    for (genvar t = 0; t < NUM_OUT; t++) begin : g_out
        pwm_trig_out i_out (
            .clk    (clk),
            .rst    (rst),
            .evt_i  (evt),
            .sel_i  (sel_arr[t]),
            .arm_i  (arm_arr[t]),
            .trig_o (trig_arr[t])
        );
    end

    assign cnt_o   = cnt;
    assign trig0_o = trig_arr[0];
    assign trig1_o = trig_arr[1];
endmodule

// File: rtl/pwm_pair_adc_trig_chk.sv
module pwm_pair_adc_trig_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] top_i,
    input logic [CNT_W-1:0] cmp0_i,
    input logic [CNT_W-1:0] cmp1_i,
    input logic [3:0]       src0_i,
    input logic             arm0_i,
    input logic [3:0]       src1_i,
    input logic             arm1_i,
    input logic [CNT_W-1:0] cnt_o,
    input logic             trig0_o,
    input logic             trig1_o
);
    logic src0_reserved;
    assign src0_reserved = (src0_i inside {4'h5, 4'h6, 4'h7}) || (src0_i >= 4'hA);

    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (top_i != '0 && cnt_o != '0 && cnt_o < top_i)
        |=> (cnt_o == $past(cnt_o) + CNT_W'(1) || cnt_o == $past(cnt_o) - CNT_W'(1)));

    // R2
    flat_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (top_i == '0) |=> (cnt_o == '0));

    // R11
    disarmed0_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !arm0_i |=> !trig0_o);

    // R11
    disarmed1_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !arm1_i |=> !trig1_o);

    // R10
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        src0_reserved |=> !trig0_o);

    // R4
    zero_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (arm0_i && src0_i == 4'h0 && cnt_o == '0) |=> trig0_o);

    // R7
    rise_match_chk: assert property (@(posedge clk) disable iff (rst)
        (arm0_i && src0_i == 4'h3) |=> (!trig0_o || $past(cnt_o == cmp0_i)));
endmodule

bind pwm_pair_adc_trig pwm_pair_adc_trig_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_pwm_pair_adc_trig.sv
module test_pwm_pair_adc_trig;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] top_i = '0, cmp0_i = '0, cmp1_i = '0;
    logic [3:0]   src0_i = '0, src1_i = '0;
    logic         arm0_i = 1'b0, arm1_i = 1'b0;
    logic [W-1:0] cnt_o;
    logic         trig0_o, trig1_o;

    int vectors = 0;
    int bad = 0;
    string cnt_tag = "R2";

    // bench reference state
    logic [W-1:0] m_cnt = '0;
    logic         m_rising = 1'b1;
    logic         x0 = 1'b0, x1 = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_pair_adc_trig i_pwm_pair_adc_trig (
        .clk(clk), .rst(rst), .top_i(top_i), .cmp0_i(cmp0_i), .cmp1_i(cmp1_i),
        .src0_i(src0_i), .arm0_i(arm0_i), .src1_i(src1_i), .arm1_i(arm1_i),
        .cnt_o(cnt_o), .trig0_o(trig0_o), .trig1_o(trig1_o)
    );

    function automatic logic want(logic [3:0] s, logic arm, logic [W-1:0] c,
                                  logic up, logic [W-1:0] tp,
                                  logic [W-1:0] ca, logic [W-1:0] cb);
        logic z, t, ar, af, br, bf;
        z  = (c == 0);
        t  = (c == tp);
        ar = (c == ca) && up && (ca != tp);
        af = (c == ca) && !up && (ca != 0);
        br = (c == cb) && up && (cb != tp);
        bf = (c == cb) && !up && (cb != 0);
        if (!arm) return 1'b0;
        case (s)
            4'h0: return z;
            4'h1: return t;
            4'h2: return z || t;
            4'h3: return ar;
            4'h4: return af;
            4'h8: return br;
            4'h9: return bf;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] s, logic arm);
        if (!arm) return "R11";
        case (s)
            4'h0: return "R4";
            4'h1: return "R5";
            4'h2: return "R6";
            4'h3, 4'h4: return (s == 4'h3) ? "R7" : "R8";
            4'h8, 4'h9: return "R9";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        logic up;
        if (rst) begin
            m_cnt = '0; m_rising = 1'b1; x0 = 1'b0; x1 = 1'b0;
        end else begin
            up = (m_cnt == 0) ? 1'b1 : (m_rising && m_cnt < top_i);
            x0 = want(src0_i, arm0_i, m_cnt, up, top_i, cmp0_i, cmp1_i);
            x1 = want(src1_i, arm1_i, m_cnt, up, top_i, cmp0_i, cmp1_i);
            m_rising = up;
            if (top_i == 0) m_cnt = '0;
            else if (up) m_cnt = m_cnt + 1'b1;
            else m_cnt = m_cnt - 1'b1;
        end
    end

    // reports use the select code in force at the edge that produced the output
    logic [3:0] s0_prev, s1_prev;
    logic       a0_prev, a1_prev;
    always @(posedge clk) begin
        s0_prev <= src0_i; s1_prev <= src1_i; a0_prev <= arm0_i; a1_prev <= arm1_i;
    end

    task automatic check();
        vectors++;
        if (cnt_o !== m_cnt) begin
            bad++;
            $display("FAIL %s count: got %0d expected %0d", cnt_tag, cnt_o, m_cnt);
        end
        vectors++;
        if (trig0_o !== x0) begin
            bad++;
            $display("FAIL %s trig0 src=%h: got %b expected %b",
                     req_of(s0_prev, a0_prev), s0_prev, trig0_o, x0);
        end
        vectors++;
        if (trig1_o !== x1) begin
            bad++;
            $display("FAIL %s/R12 trig1 src=%h: got %b expected %b",
                     req_of(s1_prev, a1_prev), s1_prev, trig1_o, x1);
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check();
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        rst = 1'b1; top_i = 16'd6; arm0_i = 1'b1; arm1_i = 1'b1;
        run(3);
        @(negedge clk); rst = 1'b0;

        // directed sweep of every select code, both enables (R4..R11)
        cmp0_i = 16'd2; cmp1_i = 16'd4;
        for (int code = 0; code < 16; code++) begin
            for (int e = 0; e < 2; e++) begin
                src0_i = 4'(code); src1_i = 4'(15 - code);
                arm0_i = e[0]; arm1_i = !e[0];
                run(16);
            end
        end

        // R7 R8 turning-point corners: compare at 0, at top, above top
        src0_i = 4'h3; src1_i = 4'h4; arm0_i = 1'b1; arm1_i = 1'b1;
        cmp0_i = 16'd0; run(20);
        cmp0_i = 16'd6; run(20);
        cmp0_i = 16'd7; run(20);
        src0_i = 4'h8; src1_i = 4'h9; cmp1_i = 16'd0; run(20);
        cmp1_i = 16'd6; run(20);

        // R12 different events on each output
        src0_i = 4'h0; src1_i = 4'h1; run(20);

        // R2 flat top of zero
        top_i = 16'd0; src0_i = 4'h2; run(8);
        top_i = 16'd1; run(8);

        // R3 lower the top while rising
        cnt_tag = "R3";
        top_i = 16'd10;
        while (!(m_rising && m_cnt == 16'd7)) run(1);
        top_i = 16'd4; run(12);
        top_i = 16'd7; run(4);
        top_i = 16'd2; run(12);
        cnt_tag = "R2";

        // random segments
        for (int k = 0; k < 400; k++) begin
            int tp;
            tp = $urandom_range(0, 12);
            top_i  = W'(tp);
            cmp0_i = W'($urandom_range(0, tp + 1));
            cmp1_i = W'($urandom_range(0, tp + 1));
            src0_i = 4'($urandom_range(0, 15));
            src1_i = 4'($urandom_range(0, 15));
            arm0_i = ($urandom_range(0, 3) != 0);
            arm1_i = ($urandom_range(0, 3) != 0);
            run($urandom_range(3, 30));
        end

        // R1 reset in mid-run
        rst = 1'b1; run(2);
        rst = 1'b0; run(5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end
endmodule